// File: doc/BRIEF.md
# Per-CPU Private Window Address Decoder

This block sits in front of the private peripheral window that up to four processor cores share. Each access carries a 12-bit offset into the 4 KB window, the ID of the core that issued it, and a read or write strobe. The decoder sends the access to exactly one target: the local snoop-control register set, one of the per-core interrupt CPU-interface banks, or one of the timer instances. For an access it cannot place, it raises an error instead. The decoder contains the snoop-control set itself. That set holds a one-bit control register, a read-only core-count register, a read-only status register and a write-only invalidate register whose writes are accepted and do nothing.

Two kinds of window reach the same banks. One page is an alias, and the requester ID picks the bank. The pages that follow it name each core's bank by address. Timer instances are numbered so that the index divided by two gives the owning core and the low bit picks timer (0) or watchdog (1). That low bit also selects the private interrupt number the instance raises: 29 for a timer, 30 for a watchdog. Decode is combinational. Only the control bit is stored.

Top module: `priv_addr_decoder`

## Requirements
- R1: Offsets 0x000–0x0FF decode to the snoop-control set only at 0x00, 0x04, 0x08 and 0x0C. On a hit, scu_sel_o is high and local_off_o equals the offset's low byte. Any other offset in this page flags err_o, and so does a write to 0x04 or 0x08.
- R2: A write to offset 0x00 stores wdata_i bit 0 at the next clock edge. Reads of 0x00 return that bit in bit 0 with all other bits zero. The stored bit is 0 after reset.
- R3: A read of 0x04 returns NUM_CPUS−1 in bits 1:0, with other bits zero. A read of 0x08 returns zero.
- R4: A write to 0x0C raises no error and leaves the control bit unchanged.
- R5: Offsets 0x100–0x1FF select the CPU-interface bank of the requester (bank_o = cpu_id_i), with local_off_o equal to the offset's low byte.
- R6: Offsets 0x200–0x5FF select the CPU-interface bank addr[11:8]−2, with local_off_o equal to the offset's low byte.
- R7: Offsets 0x600–0x6FF select the requester's timers, and 0x700–0xAFF select those of core addr[11:8]−7. tmr_idx_o = {core, addr[5]} and local_off_o = addr[3:0] zero-extended. Inside a core's 256-byte timer page, only 0x00–0x0F and 0x20–0x2F are valid. All other offsets there flag err_o.
- R8: While tmr_sel_o is high, irq_num_o = 29 + tmr_idx_o[0] and bank_o names the owning core. irq_num_o is zero otherwise.
- R9: Any access at offset 0xB00 or above flags err_o.
- R10: At most one select is high. With neither rd_i nor wr_i high, or with err_o high, every select, bank_o, tmr_idx_o and local_off_o are zero. err_o is zero when there is no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Offset into the private window |
| cpu_id_i | input | CPU_W (2) | ID of the requesting core |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W (32) | Write data |
| scu_sel_o | output | 1 | Snoop-control register set selected |
| gic_sel_o | output | 1 | CPU-interface bank selected |
| tmr_sel_o | output | 1 | Timer instance selected |
| bank_o | output | CPU_W (2) | Core whose bank or timer is addressed |
| tmr_idx_o | output | CPU_W+1 (3) | Timer instance index |
| local_off_o | output | 8 | Offset inside the selected target |
| irq_num_o | output | 5 | Private interrupt number of the selected timer instance |
| err_o | output | 1 | Bus error for an undecodable access |
| scu_rdata_o | output | DATA_W (32) | Snoop-control read data |

## Verification
Assertions check the following on every cycle: the selects are mutually exclusive, an idle or failed access drives nothing, the alias page picks the requester's bank, high offsets raise an error, and a timer's interrupt number follows its index. They also check that the control bit tracks writes to it and survives invalidate writes. Only the bench's scenarios show the rest. These are the exact bank and local-offset arithmetic of the explicit pages, the holes in the timer page and the control page, the error on writes to the read-only registers, and the values read back from the control, core-count and status registers.

// File: rtl/priv_dec_pkg.sv
package priv_dec_pkg;
  typedef enum logic [1:0] {TGT_NONE, TGT_SCU, TGT_GIC, TGT_TMR} tgt_e;
  localparam logic [4:0] TMR_IRQ_BASE = 5'd29;
endpackage

// File: rtl/priv_win_decode.sv
module priv_win_decode
  import priv_dec_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int CPU_W    = 2
) (
  input  logic [11:0]      addr_i,
  input  logic [CPU_W-1:0] cpu_id_i,
  output tgt_e             tgt_o,
  output logic [CPU_W-1:0] bank_o,
  output logic             bad_o
);
  localparam logic [3:0] NCPU4 = 4'(NUM_CPUS);

  logic [3:0] page;
  logic [3:0] rel;
  logic [7:0] low;

  assign page = addr_i[11:8];
  assign low  = addr_i[7:0];

  always_comb begin
    tgt_o  = TGT_NONE;
    bank_o = '0;
    bad_o  = 1'b0;
    rel    = '0;
    if (page == 4'h0) begin
      tgt_o = TGT_SCU;
      bad_o = !(low == 8'h00 || low == 8'h04 || low == 8'h08 || low == 8'h0C);
    end else if (page == 4'h1) begin
      tgt_o  = TGT_GIC;
      bank_o = cpu_id_i;
    end else if (page >= 4'h2 && page <= 4'h5) begin
      rel    = page - 4'h2;
      tgt_o  = TGT_GIC;
      bank_o = rel[CPU_W-1:0];
      bad_o  = (rel >= NCPU4);
    end else if (page == 4'h6) begin
      tgt_o  = TGT_TMR;
      bank_o = cpu_id_i;
      bad_o  = (low[7:6] != 2'b00) || low[4];
    end else if (page >= 4'h7 && page <= 4'hA) begin
      rel    = page - 4'h7;
      tgt_o  = TGT_TMR;
      bank_o = rel[CPU_W-1:0];
      bad_o  = (rel >= NCPU4) || (low[7:6] != 2'b00) || low[4];
    end else begin
      bad_o = 1'b1;
    end
  end
endmodule

// File: rtl/priv_scu_regs.sv
module priv_scu_regs #(
  parameter int NUM_CPUS = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wr_bad_o
);
  localparam logic [1:0] CPU_CNT_M1 = 2'(NUM_CPUS - 1);

  logic ctrl_q;
  logic ctrl_we;

  // read-only registers reject writes
  assign wr_bad_o = sel_i && wr_i && (off_i == 8'h04 || off_i == 8'h08);
  assign ctrl_we  = sel_i && wr_i && (off_i == 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= 1'b0;
    else if (ctrl_we) ctrl_q <= wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && rd_i) begin
      case (off_i)
        8'h00:   rdata_o[0]   = ctrl_q;
        8'h04:   rdata_o[1:0] = CPU_CNT_M1;
        default: rdata_o      = '0;
      endcase
    end
  end

  assert_ctrl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && off_i == 8'h00) |=> (ctrl_q == $past(wdata_i[0])));

  assert_inval_noop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && off_i == 8'h0C) |=> $stable(ctrl_q));
endmodule

// File: rtl/priv_tmr_map.sv
module priv_tmr_map
  import priv_dec_pkg::*;
#(
  parameter int CPU_W = 2
) (
  input  logic             hit_i,
  input  logic [CPU_W-1:0] bank_i,
  input  logic [7:0]       off_i,
  output logic [CPU_W:0]   idx_o,
  output logic [7:0]       loff_o,
  output logic [4:0]       irq_num_o
);
  logic is_wd;
  assign is_wd = off_i[5];

  always_comb begin
    idx_o     = '0;
    loff_o    = '0;
    irq_num_o = '0;
    if (hit_i) begin
      idx_o     = {bank_i, is_wd};
      loff_o    = {4'b0, off_i[3:0]};
      irq_num_o = TMR_IRQ_BASE + {4'b0, is_wd};
    end
  end
endmodule

// File: rtl/priv_addr_decoder.sv
module priv_addr_decoder
  import priv_dec_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int DATA_W   = 32,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [11:0]       addr_i,
  input  logic [CPU_W-1:0]  cpu_id_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              scu_sel_o,
  output logic              gic_sel_o,
  output logic              tmr_sel_o,
  output logic [CPU_W-1:0]  bank_o,
  output logic [CPU_W:0]    tmr_idx_o,
  output logic [7:0]        local_off_o,
  output logic [4:0]        irq_num_o,
  output logic              err_o,
  output logic [DATA_W-1:0] scu_rdata_o
);
  tgt_e             tgt;
  logic [CPU_W-1:0] win_bank;
  logic             win_bad;
  logic             access;
  logic             scu_hit;
  logic             scu_wr_bad;
  logic             tmr_hit;
  logic [7:0]       tmr_loff;

  assign access = rd_i || wr_i;

  priv_win_decode #(.NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W)) u_win (
    .addr_i  (addr_i),
    .cpu_id_i(cpu_id_i),
    .tgt_o   (tgt),
    .bank_o  (win_bank),
    .bad_o   (win_bad)
  );

  assign scu_hit = access && !win_bad && (tgt == TGT_SCU);

  priv_scu_regs #(.NUM_CPUS(NUM_CPUS), .DATA_W(DATA_W)) u_scu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (scu_hit),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .off_i   (addr_i[7:0]),
    .wdata_i (wdata_i),
    .rdata_o (scu_rdata_o),
    .wr_bad_o(scu_wr_bad)
  );

  assign tmr_hit = access && !win_bad && (tgt == TGT_TMR);

  priv_tmr_map #(.CPU_W(CPU_W)) u_tmr (
    .hit_i    (tmr_hit),
    .bank_i   (win_bank),
    .off_i    (addr_i[7:0]),
    .idx_o    (tmr_idx_o),
    .loff_o   (tmr_loff),
    .irq_num_o(irq_num_o)
  );

  assign err_o     = access && (win_bad || scu_wr_bad);
  assign scu_sel_o = scu_hit && !scu_wr_bad;
  assign gic_sel_o = access && !win_bad && (tgt == TGT_GIC);
  assign tmr_sel_o = tmr_hit;

  always_comb begin
    bank_o      = '0;
    local_off_o = '0;
    if (gic_sel_o) begin
      bank_o      = win_bank;
      local_off_o = addr_i[7:0];
    end else if (tmr_sel_o) begin
      bank_o      = win_bank;
      local_off_o = tmr_loff;
    end else if (scu_sel_o) begin
      local_off_o = addr_i[7:0];
    end
  end

  assert_one_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scu_sel_o, gic_sel_o, tmr_sel_o}));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access |-> (!err_o && !scu_sel_o && !gic_sel_o && !tmr_sel_o));

  assert_err_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!scu_sel_o && !gic_sel_o && !tmr_sel_o));

  assert_alias_bank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && addr_i[11:8] == 4'h1) |-> (gic_sel_o && bank_o == cpu_id_i));

  assert_high_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access && addr_i >= 12'hB00) |-> err_o);

  assert_irq_num_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_sel_o |-> (irq_num_o == TMR_IRQ_BASE + {4'b0, tmr_idx_o[0]}));
endmodule

// File: tb/priv_addr_decoder_tb.sv
module priv_addr_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [1:0]  cpu_id_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        scu_sel_o, gic_sel_o, tmr_sel_o, err_o;
  logic [1:0]  bank_o;
  logic [2:0]  tmr_idx_o;
  logic [7:0]  local_off_o;
  logic [4:0]  irq_num_o;
  logic [31:0] scu_rdata_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  priv_addr_decoder u_dut (
    .clk_i, .rst_ni, .addr_i, .cpu_id_i, .rd_i, .wr_i, .wdata_i,
    .scu_sel_o, .gic_sel_o, .tmr_sel_o, .bank_o, .tmr_idx_o,
    .local_off_o, .irq_num_o, .err_o, .scu_rdata_o
  );

  typedef struct packed {
    logic [11:0] addr;
    logic [1:0]  cpu;
    logic        wr;
    logic [2:0]  sel;   // {scu, gic, tmr}
    logic [1:0]  bank;
    logic [2:0]  tidx;
    logic [7:0]  loff;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{12'h000, 2'd0, 1'b0, 3'b100, 2'd0, 3'd0, 8'h00, 1'b0, 4'd1},  // R1
    '{12'h00C, 2'd2, 1'b0, 3'b100, 2'd0, 3'd0, 8'h0C, 1'b0, 4'd1},  // R1
    '{12'h010, 2'd0, 1'b0, 3'b000, 2'd0, 3'd0, 8'h00, 1'b1, 4'd1},  // R1 hole
    '{12'h004, 2'd1, 1'b1, 3'b000, 2'd0, 3'd0, 8'h00, 1'b1, 4'd1},  // R1 write read-only
    '{12'h104, 2'd2, 1'b0, 3'b010, 2'd2, 3'd0, 8'h04, 1'b0, 4'd5},  // R5
    '{12'h1FC, 2'd3, 1'b0, 3'b010, 2'd3, 3'd0, 8'hFC, 1'b0, 4'd5},  // R5
    '{12'h200, 2'd3, 1'b0, 3'b010, 2'd0, 3'd0, 8'h00, 1'b0, 4'd6},  // R6
    '{12'h5F0, 2'd0, 1'b0, 3'b010, 2'd3, 3'd0, 8'hF0, 1'b0, 4'd6},  // R6
    '{12'h308, 2'd1, 1'b1, 3'b010, 2'd1, 3'd0, 8'h08, 1'b0, 4'd6},  // R6
    '{12'h604, 2'd1, 1'b0, 3'b001, 2'd1, 3'd2, 8'h04, 1'b0, 4'd7},  // R7 alias timer
    '{12'h62C, 2'd3, 1'b0, 3'b001, 2'd3, 3'd7, 8'h0C, 1'b0, 4'd7},  // R7 alias watchdog
    '{12'h700, 2'd2, 1'b0, 3'b001, 2'd0, 3'd0, 8'h00, 1'b0, 4'd7},  // R7
    '{12'hA20, 2'd0, 1'b0, 3'b001, 2'd3, 3'd7, 8'h00, 1'b0, 4'd7},  // R7
    '{12'h824, 2'd0, 1'b0, 3'b001, 2'd1, 3'd3, 8'h04, 1'b0, 4'd7},  // R7
    '{12'h610, 2'd0, 1'b0, 3'b000, 2'd0, 3'd0, 8'h00, 1'b1, 4'd7},  // R7 hole
    '{12'h640, 2'd2, 1'b0, 3'b000, 2'd0, 3'd0, 8'h00, 1'b1, 4'd7},  // R7 hole
    '{12'hB00, 2'd0, 1'b0, 3'b000, 2'd0, 3'd0, 8'h00, 1'b1, 4'd9},  // R9
    '{12'hFFC, 2'd1, 1'b1, 3'b000, 2'd0, 3'd0, 8'h00, 1'b1, 4'd9},  // R9
    '{12'h008, 2'd0, 1'b1, 3'b000, 2'd0, 3'd0, 8'h00, 1'b1, 4'd1},  // R1 write read-only
    '{12'h008, 2'd0, 1'b0, 3'b100, 2'd0, 3'd0, 8'h08, 1'b0, 4'd1}   // R1
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic [1:0] c,
                        input logic r, input logic w, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; cpu_id_i = c; rd_i = r; wr_i = w; wdata_i = d;
    #5;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 reset value of the control bit
    access(12'h000, 2'd0, 1'b1, 1'b0, 32'h0);
    chk("R2", "reset ctrl", scu_rdata_o, 32'h0);

    // R10 idle: no select, no error
    access(12'hB00, 2'd0, 1'b0, 1'b0, 32'h0);
    chk("R10", "idle outputs",
        {20'b0, scu_sel_o, gic_sel_o, tmr_sel_o, err_o, bank_o, tmr_idx_o, local_off_o},
        32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d[v%0d]", VECS[i].req, i);
      access(VECS[i].addr, VECS[i].cpu, !VECS[i].wr, VECS[i].wr, 32'h0);
      chk(tag, "sel", {29'b0, scu_sel_o, gic_sel_o, tmr_sel_o}, {29'b0, VECS[i].sel});
      chk(tag, "err", {31'b0, err_o}, {31'b0, VECS[i].err});
      chk(tag, "bank", {30'b0, bank_o}, {30'b0, VECS[i].bank});
      chk(tag, "tidx", {29'b0, tmr_idx_o}, {29'b0, VECS[i].tidx});
      chk(tag, "loff", {24'b0, local_off_o}, {24'b0, VECS[i].loff});
      // R8 interrupt number follows the watchdog bit
      chk("R8", "irq_num", {27'b0, irq_num_o},
          VECS[i].sel[0] ? 32'd29 + {31'b0, VECS[i].tidx[0]} : 32'd0);
    end

    // R2 set, then only bit 0 stored
    access(12'h000, 2'd1, 1'b0, 1'b1, 32'h0000_0001);
    access(12'h000, 2'd1, 1'b1, 1'b0, 32'h0);
    chk("R2", "ctrl after write 1", scu_rdata_o, 32'h1);
    access(12'h000, 2'd2, 1'b0, 1'b1, 32'hFFFF_FFFE);
    access(12'h000, 2'd2, 1'b1, 1'b0, 32'h0);
    chk("R2", "ctrl after write FFFFFFFE", scu_rdata_o, 32'h0);
    access(12'h000, 2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    access(12'h000, 2'd0, 1'b1, 1'b0, 32'h0);
    chk("R2", "ctrl upper bits zero", scu_rdata_o, 32'h1);

    // R4 invalidate write accepted, control unchanged
    access(12'h00C, 2'd3, 1'b0, 1'b1, 32'h0);
    chk("R4", "inval err", {31'b0, err_o}, 32'h0);
    chk("R4", "inval sel", {31'b0, scu_sel_o}, 32'h1);
    access(12'h000, 2'd0, 1'b1, 1'b0, 32'h0);
    chk("R4", "ctrl after inval", scu_rdata_o, 32'h1);

    // R3 core count and status
    access(12'h004, 2'd0, 1'b1, 1'b0, 32'h0);
    chk("R3", "config read", scu_rdata_o, 32'h3);
    access(12'h008, 2'd0, 1'b1, 1'b0, 32'h0);
    chk("R3", "status read", scu_rdata_o, 32'h0);

    // R1 rejected write to config leaves registers alone
    access(12'h004, 2'd0, 1'b0, 1'b1, 32'h0);
    access(12'h004, 2'd0, 1'b1, 1'b0, 32'h0);
    chk("R1", "config after bad write", scu_rdata_o, 32'h3);
    access(12'h000, 2'd0, 1'b1, 1'b0, 32'h0);
    chk("R1", "ctrl after bad write", scu_rdata_o, 32'h1);

    // R10 error access drives no target fields
    access(12'hC40, 2'd3, 1'b1, 1'b0, 32'h0);
    chk("R10", "err fields",
        {19'b0, scu_sel_o, gic_sel_o, tmr_sel_o, bank_o, tmr_idx_o, local_off_o}, 32'h0);

    access(12'h000, 2'd0, 1'b0, 1'b0, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule